// File: doc/BRIEF.md
# DAC Register Update Controller

This block is the digital core of a serial-input DAC. A shift-register front end collects a frame while the frame-select line `sync_i` is low and presents the whole frame word and its bit count. The controller acts on the rising edge of `sync_i`. It keeps an input register, a DAC register that drives the converter code, and a small control register with sticky fault flags. Reading the control register back clears those flags.

The DAC register can be loaded in two ways, and the level of `ldac_n` during the frame picks between them. If `ldac_n` is held low while the frame shifts in, the load happens at the end of the frame. If `ldac_n` is held high, the load waits for a later falling edge of `ldac_n`. An asynchronous clear input forces the output to a programmable clear code. A fault output (`alert_n`) reports three things: that the block is not yet configured, that a short-circuit or brownout event was seen, or that the die is over temperature. If an over-temperature event occurs while a control bit enables it, the block latches a power-down state and stops responding.

Top module: `dac_update_ctrl`

## Requirements
- R1: After a hardware reset, `dac_out` is 0, the input register is 0, `alert_n` is low, `pd_o` is low and `rb_valid` is low.
- R2: Frame layout: the command sits in `frame_word[23:20]` and the data in `frame_word[15:0]`. Command 0x1 writes the input register. If `ldac_n` was low while `sync_i` was low, the same frame also loads the DAC register. The new value appears on `dac_out` at the clock edge that first samples `sync_i` high.
- R3: If `ldac_n` was high during the frame, `dac_out` does not change at the rising edge of `sync_i`. A falling edge of `ldac_n` while `sync_i` is high copies the input register to `dac_out` at that edge. Without a frame, an `ldac_n` fall or a clear, `dac_out` holds its value.
- R4: Command 0x2 copies the input register to the DAC register. Command 0x3 writes the data to both registers. Every command code not listed in these requirements leaves all state unchanged.
- R5: A frame whose `frame_len` differs from 24 is ignored.
- R6: A falling edge of `clear_n` passes through a two-flop synchroniser and then loads `dac_out` at the third clock edge. The value loaded depends on control bits [10:9]: 00 gives 0x0000, 01 gives 0x8000, 10 gives 0xFFFF, and 11 gives 0x0000. The clear value stays until the next DAC load.
- R7: If a clear and a DAC load fall in the same cycle, the clear wins. The input register is still written by that frame.
- R8: `alert_n` stays low from reset until the first control write (command 0x4, which stores `data[10:0]`). After that it is high while there is no fault.
- R9: A pulse on `sc_evt` sets sticky bit 12 and a pulse on `bo_evt` sets sticky bit 11. Either bit drives `alert_n` low. Readback (command 0xB) returns {bit 12, bit 11, control[10:0]} on `rb_data` with a one-cycle `rb_valid` pulse, and it clears both bits.
- R10: While `over_temp` is high, `alert_n` is low. If control bit 8 is 0, there is no other effect.
- R11: If control bit 8 is 1, `over_temp` sets `pd_o`. `pd_o` stays set until a hardware reset, and in the meantime frames, `ldac_n` and `clear_n` are ignored.
- R12: Command 0xF returns the block to its reset state: `dac_out` is 0, the input register is 0, `alert_n` is low and the fault flags are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous hardware reset, active low |
| sync_i | input | 1 | Frame select; low while a frame shifts in |
| ldac_n | input | 1 | Load control; level during frame picks mode, fall loads DAC |
| clear_n | input | 1 | Asynchronous clear request, falling-edge active |
| frame_word | input | 24 | Frame from the shift register |
| frame_len | input | 5 | Number of bits shifted in the frame |
| sc_evt | input | 1 | Short-circuit event pulse |
| bo_evt | input | 1 | Brownout event pulse |
| over_temp | input | 1 | Over-temperature level |
| dac_out | output | 16 | DAC register value |
| alert_n | output | 1 | Fault indication, active low |
| pd_o | output | 1 | Latched power-down |
| rb_data | output | 16 | Control readback word |
| rb_valid | output | 1 | One-cycle strobe for `rb_data` |

## Verification
Most internal errors show up on `dac_out` one edge after the event that should have moved it. Examples are a wrong load-mode capture, a lost input-register value or a wrong clear-code select. The input register has no port of its own, so it is read out through a later `ldac_n` fall, which exposes a corrupt value one edge later. A sticky flag or configuration flag in the wrong state shows on `alert_n` at once. The same flag shows on `rb_data` at the edge that ends a readback frame.

// File: rtl/dacu_pkg.sv
package dacu_pkg;
   localparam int CMD_W = 4;

   typedef enum logic [CMD_W-1:0] {
      CMD_NOP      = 4'h0,
      CMD_WR_IN    = 4'h1,
      CMD_UPD      = 4'h2,
      CMD_WR_UPD   = 4'h3,
      CMD_WR_CTL   = 4'h4,
      CMD_RD_CTL   = 4'hB,
      CMD_SOFT_RST = 4'hF
   } cmd_e;

   // control word layout (decoded by readback and by clear/ETS logic)
   localparam int CTL_SC     = 12;
   localparam int CTL_BO     = 11;
   localparam int CTL_CLR_HI = 10;
   localparam int CTL_CLR_LO = 9;
   localparam int CTL_ETS    = 8;
   localparam int CTL_WR_W   = 11;
   localparam int CTL_MIN_DW = 13;
endpackage

// File: rtl/dacu_fall_sync.sv
module dacu_fall_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic fall
);
   if (STAGES < 2) begin : g_bad_stages
      $error("dacu_fall_sync: STAGES must be at least 2");
   end

   // STAGES synchroniser flops plus one history flop for edge detection
   logic [STAGES:0] sh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh <= '1;
      else        sh <= {sh[STAGES-1:0], din};
   end

   assign fall = sh[STAGES] & ~sh[STAGES-1];
endmodule

// File: rtl/dacu_frame_dec.sv
module dacu_frame_dec
   import dacu_pkg::*;
#(
   parameter int DW         = 16,
   parameter int FRAME_BITS = 24,
   parameter int LEN_W      = 5
) (
   input  logic                  strobe,
   input  logic [FRAME_BITS-1:0] word,
   input  logic [LEN_W-1:0]      len,
   output logic                  do_wr_in,
   output logic                  do_upd,
   output logic                  do_wr_upd,
   output logic                  do_wr_ctl,
   output logic                  do_rd_ctl,
   output logic                  do_srst,
   output logic [DW-1:0]         data
);
   logic len_ok;
   cmd_e cmd;

   assign len_ok = strobe && (len == LEN_W'(FRAME_BITS));
   assign cmd    = cmd_e'(word[FRAME_BITS-1 -: CMD_W]);
   assign data   = word[DW-1:0];

   always_comb begin
      do_wr_in  = 1'b0;
      do_upd    = 1'b0;
      do_wr_upd = 1'b0;
      do_wr_ctl = 1'b0;
      do_rd_ctl = 1'b0;
      do_srst   = 1'b0;
      if (len_ok) begin
         case (cmd)
            CMD_WR_IN:    do_wr_in  = 1'b1;
            CMD_UPD:      do_upd    = 1'b1;
            CMD_WR_UPD:   do_wr_upd = 1'b1;
            CMD_WR_CTL:   do_wr_ctl = 1'b1;
            CMD_RD_CTL:   do_rd_ctl = 1'b1;
            CMD_SOFT_RST: do_srst   = 1'b1;
            default:      ;
         endcase
      end
   end
endmodule

// File: rtl/dacu_clear_code.sv
module dacu_clear_code #(
   parameter int DW = 16
) (
   input  logic [1:0]    sel,
   output logic [DW-1:0] code
);
   always_comb begin
      case (sel)
         2'b01:   code = {1'b1, {(DW-1){1'b0}}};
         2'b10:   code = '1;
         default: code = '0;
      endcase
   end
endmodule

// File: rtl/dac_update_ctrl.sv
module dac_update_ctrl
   import dacu_pkg::*;
#(
   parameter int DW          = 16,
   parameter int FRAME_BITS  = 24,
   parameter int SYNC_STAGES = 2,
   localparam int LEN_W      = $clog2(FRAME_BITS + 1)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  sync_i,
   input  logic                  ldac_n,
   input  logic                  clear_n,
   input  logic [FRAME_BITS-1:0] frame_word,
   input  logic [LEN_W-1:0]      frame_len,
   input  logic                  sc_evt,
   input  logic                  bo_evt,
   input  logic                  over_temp,
   output logic [DW-1:0]         dac_out,
   output logic                  alert_n,
   output logic                  pd_o,
   output logic [DW-1:0]         rb_data,
   output logic                  rb_valid
);
   if (DW < CTL_MIN_DW) begin : g_bad_dw
      $error("dac_update_ctrl: DW too small for control layout");
   end
   if (FRAME_BITS < DW + CMD_W) begin : g_bad_frame
      $error("dac_update_ctrl: FRAME_BITS cannot hold command and data");
   end

   logic                sync_q, ldac_q, ldac_lvl_q;
   logic [DW-1:0]       in_q, dac_q, rb_q;
   logic [CTL_WR_W-1:0] ctl_q;
   logic                sc_q, bo_q, cfg_q, pd_q, rb_vld_q;

   logic          frame_rise, ldac_fall, clr_fall, sync_mode, pd_trip;
   logic          do_wr_in, do_upd, do_wr_upd, do_wr_ctl, do_rd_ctl, do_srst;
   logic [DW-1:0] frm_data, clr_val, rb_word;

   assign frame_rise = sync_i & ~sync_q;
   assign ldac_fall  = sync_i & sync_q & ldac_q & ~ldac_n;
   assign sync_mode  = ~ldac_lvl_q;
   assign pd_trip    = over_temp & ctl_q[CTL_ETS] & ~pd_q;

   dacu_fall_sync #(.STAGES(SYNC_STAGES)) u_clr_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (clear_n),
      .fall (clr_fall)
   );

   dacu_frame_dec #(.DW(DW), .FRAME_BITS(FRAME_BITS), .LEN_W(LEN_W)) u_dec (
      .strobe   (frame_rise),
      .word     (frame_word),
      .len      (frame_len),
      .do_wr_in (do_wr_in),
      .do_upd   (do_upd),
      .do_wr_upd(do_wr_upd),
      .do_wr_ctl(do_wr_ctl),
      .do_rd_ctl(do_rd_ctl),
      .do_srst  (do_srst),
      .data     (frm_data)
   );

   dacu_clear_code #(.DW(DW)) u_clr_code (
      .sel (ctl_q[CTL_CLR_HI:CTL_CLR_LO]),
      .code(clr_val)
   );

   always_comb begin
      rb_word                 = '0;
      rb_word[CTL_WR_W-1:0]   = ctl_q;
      rb_word[CTL_BO]         = bo_q;
      rb_word[CTL_SC]         = sc_q;
   end

   // edge history for frame select and load strobe
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q     <= 1'b1;
         ldac_q     <= 1'b1;
         ldac_lvl_q <= 1'b1;
      end else begin
         sync_q <= sync_i;
         ldac_q <= ldac_n;
         if (!sync_i) ldac_lvl_q <= ldac_n;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         in_q     <= '0;
         dac_q    <= '0;
         ctl_q    <= '0;
         sc_q     <= 1'b0;
         bo_q     <= 1'b0;
         cfg_q    <= 1'b0;
         pd_q     <= 1'b0;
         rb_q     <= '0;
         rb_vld_q <= 1'b0;
      end else if (pd_q) begin
         rb_vld_q <= 1'b0;
      end else if (pd_trip) begin
         pd_q     <= 1'b1;
         rb_vld_q <= 1'b0;
      end else if (do_srst) begin
         in_q     <= '0;
         dac_q    <= '0;
         ctl_q    <= '0;
         sc_q     <= 1'b0;
         bo_q     <= 1'b0;
         cfg_q    <= 1'b0;
         rb_q     <= '0;
         rb_vld_q <= 1'b0;
      end else begin
         rb_vld_q <= do_rd_ctl;
         if (do_rd_ctl) rb_q <= rb_word;
         if (do_wr_in || do_wr_upd) in_q <= frm_data;
         if (clr_fall)
            dac_q <= clr_val;
         else if (do_wr_upd || (do_wr_in && sync_mode))
            dac_q <= frm_data;
         else if (do_upd || ldac_fall)
            dac_q <= in_q;
         if (do_wr_ctl) begin
            ctl_q <= frm_data[CTL_WR_W-1:0];
            cfg_q <= 1'b1;
         end
         sc_q <= sc_evt | (sc_q & ~do_rd_ctl);
         bo_q <= bo_evt | (bo_q & ~do_rd_ctl);
      end
   end

   assign dac_out  = dac_q;
   assign alert_n  = cfg_q & ~sc_q & ~bo_q & ~over_temp;
   assign pd_o     = pd_q;
   assign rb_data  = rb_q;
   assign rb_valid = rb_vld_q;
endmodule

// File: rtl/dac_update_ctrl_chk.sv
module dac_update_ctrl_chk #(
   parameter int DW = 16
) (
   input logic          clk,
   input logic          rst_n,
   input logic          pd_q,
   input logic          pd_trip,
   input logic          frame_rise,
   input logic          ldac_fall,
   input logic          clr_fall,
   input logic          sync_mode,
   input logic          do_wr_in,
   input logic          do_srst,
   input logic          do_rd_ctl,
   input logic [DW-1:0] frm_data,
   input logic [DW-1:0] in_q,
   input logic [DW-1:0] clr_val,
   input logic [DW-1:0] dac_out,
   input logic          alert_n,
   input logic          sc_q,
   input logic          cfg_q,
   input logic          rb_valid,
   input logic          pd_o
);
   assert_sync_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (do_wr_in && sync_mode && !clr_fall && !pd_q && !pd_trip) |=> dac_out == $past(frm_data));

   assert_async_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (ldac_fall && !clr_fall && !pd_q && !pd_trip) |=> dac_out == $past(in_q));

   assert_dac_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!frame_rise && !ldac_fall && !clr_fall) |=> $stable(dac_out));

   // clear value prevails over any load in the same cycle (R7)
   assert_clear_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_fall && !pd_q && !pd_trip && !do_srst) |=> dac_out == $past(clr_val));

   assert_alert_unconfigured_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_q |-> !alert_n);

   assert_alert_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      sc_q |-> !alert_n);

   assert_rb_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
      rb_valid |-> $past(do_rd_ctl));

   assert_pd_latched_R11: assert property (@(posedge clk) disable iff (!rst_n)
      pd_o |=> pd_o);
endmodule

bind dac_update_ctrl dac_update_ctrl_chk #(.DW(DW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .pd_q      (pd_q),
   .pd_trip   (pd_trip),
   .frame_rise(frame_rise),
   .ldac_fall (ldac_fall),
   .clr_fall  (clr_fall),
   .sync_mode (sync_mode),
   .do_wr_in  (do_wr_in),
   .do_srst   (do_srst),
   .do_rd_ctl (do_rd_ctl),
   .frm_data  (frm_data),
   .in_q      (in_q),
   .clr_val   (clr_val),
   .dac_out   (dac_out),
   .alert_n   (alert_n),
   .sc_q      (sc_q),
   .cfg_q     (cfg_q),
   .rb_valid  (rb_valid),
   .pd_o      (pd_o)
);

// File: tb/dac_update_ctrl_bench.sv
module dac_update_ctrl_bench;
   localparam int DW    = 16;
   localparam int FB    = 24;
   localparam int LEN_W = 5;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          sync_i = 1'b1;
   logic          ldac_n = 1'b1;
   logic          clear_n = 1'b1;
   logic [FB-1:0] frame_word = '0;
   logic [LEN_W-1:0] frame_len = '0;
   logic          sc_evt = 1'b0, bo_evt = 1'b0, over_temp = 1'b0;
   logic [DW-1:0] dac_out, rb_data;
   logic          alert_n, pd_o, rb_valid;

   int n_checks = 0;
   int n_errors = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   dac_update_ctrl u_dac_update_ctrl (
      .clk(clk), .rst_n(rst_n), .sync_i(sync_i), .ldac_n(ldac_n), .clear_n(clear_n),
      .frame_word(frame_word), .frame_len(frame_len), .sc_evt(sc_evt), .bo_evt(bo_evt),
      .over_temp(over_temp), .dac_out(dac_out), .alert_n(alert_n), .pd_o(pd_o),
      .rb_data(rb_data), .rb_valid(rb_valid)
   );

   // {cmd, ldac level during frame, data, expected dac_out}
   localparam logic [36:0] VEC [8] = '{
      {4'h1, 1'b0, 16'h1234, 16'h1234},
      {4'h1, 1'b1, 16'h2222, 16'h1234},
      {4'h2, 1'b1, 16'h0000, 16'h2222},
      {4'h3, 1'b1, 16'hABCD, 16'hABCD},
      {4'h1, 1'b1, 16'h0F0F, 16'hABCD},
      {4'h5, 1'b0, 16'h5555, 16'hABCD},
      {4'h1, 1'b0, 16'hFFFF, 16'hFFFF},
      {4'h3, 1'b0, 16'h0001, 16'h0001}
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic send_frame(input logic [3:0] c, input logic [15:0] d, input logic lv, input int len);
      @(negedge clk);
      sync_i = 1'b0; ldac_n = lv; frame_word = {c, 4'h0, d}; frame_len = len[LEN_W-1:0];
      @(negedge clk);
      @(negedge clk);
      sync_i = 1'b1;
      @(negedge clk);
   endtask

   task automatic ldac_pulse;
      ldac_n = 1'b0;
      @(negedge clk);
      ldac_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic clear_pulse;
      @(negedge clk);
      clear_n = 1'b0;
      repeat (4) @(negedge clk);
      clear_n = 1'b1;
      repeat (4) @(negedge clk);
   endtask

   task automatic hw_reset;
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_checks++; n_errors++;
         $display("FAIL watchdog: actual hung expected done");
         $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1 dac", 32'(dac_out), 32'h0);
      check("R1 alert", 32'(alert_n), 32'h0);
      check("R1 pd", 32'(pd_o), 32'h0);
      check("R1 rbvalid", 32'(rb_valid), 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 input zero", 32'(dac_out), 32'h0);
      ldac_pulse();
      check("R1 input reg zero via ldac", 32'(dac_out), 32'h0);

      // R8 first control write releases alert
      check("R8 alert before cfg", 32'(alert_n), 32'h0);
      send_frame(4'h4, 16'h0200, 1'b1, FB);
      check("R8 alert after cfg", 32'(alert_n), 32'h1);

      // table walk: R2 sync load, R3 async hold, R4 commands
      for (int i = 0; i < 8; i++) begin
         send_frame(VEC[i][36:33], VEC[i][31:16], VEC[i][32], FB);
         check("R2/R3/R4 vector", 32'(dac_out), 32'(VEC[i][15:0]));
      end

      // R3 async load on ldac fall
      send_frame(4'h1, 16'h4444, 1'b1, FB);
      check("R3 no update at sync", 32'(dac_out), 32'h0001);
      repeat (3) @(negedge clk);
      check("R3 hold", 32'(dac_out), 32'h0001);
      ldac_pulse();
      check("R3 ldac fall load", 32'(dac_out), 32'h4444);

      // R5 wrong lengths
      send_frame(4'h3, 16'h6666, 1'b0, 23);
      check("R5 short frame", 32'(dac_out), 32'h4444);
      send_frame(4'h3, 16'h6666, 1'b0, 25);
      check("R5 long frame", 32'(dac_out), 32'h4444);
      ldac_pulse();
      check("R5 input untouched", 32'(dac_out), 32'h4444);

      // R4 unknown command leaves input reg
      send_frame(4'h7, 16'h7777, 1'b1, FB);
      ldac_pulse();
      check("R4 unknown cmd ignored", 32'(dac_out), 32'h4444);

      // R6 clear codes
      clear_pulse();
      check("R6 midscale", 32'(dac_out), 32'h8000);
      send_frame(4'h4, 16'h0400, 1'b1, FB);
      check("R6 hold after clear", 32'(dac_out), 32'h8000);
      clear_pulse();
      check("R6 full scale", 32'(dac_out), 32'hFFFF);
      send_frame(4'h4, 16'h0600, 1'b1, FB);
      clear_pulse();
      check("R6 code 11 zero", 32'(dac_out), 32'h0000);
      send_frame(4'h4, 16'h0400, 1'b1, FB);
      clear_pulse();
      send_frame(4'h4, 16'h0000, 1'b1, FB);
      clear_pulse();
      check("R6 code 00 zero", 32'(dac_out), 32'h0000);
      send_frame(4'h2, 16'h0000, 1'b1, FB);
      check("R6 new load replaces clear", 32'(dac_out), 32'h4444);

      // R7 clear wins over simultaneous write-and-update
      send_frame(4'h4, 16'h0200, 1'b1, FB);
      @(negedge clk);
      clear_n = 1'b0; sync_i = 1'b0; ldac_n = 1'b1;
      frame_word = {4'h3, 4'h0, 16'h3333}; frame_len = 5'(FB);
      @(negedge clk);
      @(negedge clk);
      sync_i = 1'b1;
      @(negedge clk);
      check("R7 clear priority", 32'(dac_out), 32'h8000);
      clear_n = 1'b1;
      repeat (3) @(negedge clk);
      ldac_pulse();
      check("R7 input still written", 32'(dac_out), 32'h3333);

      // R9 sticky status and readback
      sc_evt = 1'b1;
      @(negedge clk);
      sc_evt = 1'b0;
      check("R9 sc alert", 32'(alert_n), 32'h0);
      @(negedge clk);
      check("R9 sc sticky", 32'(alert_n), 32'h0);
      send_frame(4'hB, 16'h0000, 1'b1, FB);
      check("R9 rb sc", 32'(rb_data), 32'h1200);
      check("R9 rb valid", 32'(rb_valid), 32'h1);
      check("R9 alert cleared", 32'(alert_n), 32'h1);
      @(negedge clk);
      check("R9 rb valid pulse", 32'(rb_valid), 32'h0);
      bo_evt = 1'b1;
      @(negedge clk);
      bo_evt = 1'b0;
      check("R9 bo alert", 32'(alert_n), 32'h0);
      send_frame(4'hB, 16'h0000, 1'b1, FB);
      check("R9 rb bo", 32'(rb_data), 32'h0A00);
      send_frame(4'hB, 16'h0000, 1'b1, FB);
      check("R9 rb cleared", 32'(rb_data), 32'h0200);

      // R10 over-temp with ETS clear
      over_temp = 1'b1;
      @(negedge clk);
      check("R10 alert low", 32'(alert_n), 32'h0);
      check("R10 no pd", 32'(pd_o), 32'h0);
      send_frame(4'h3, 16'h1111, 1'b1, FB);
      check("R10 still works", 32'(dac_out), 32'h1111);
      over_temp = 1'b0;
      @(negedge clk);
      check("R10 alert recovers", 32'(alert_n), 32'h1);

      // R12 software reset
      send_frame(4'h1, 16'h9999, 1'b1, FB);
      send_frame(4'hF, 16'h0000, 1'b1, FB);
      check("R12 dac zero", 32'(dac_out), 32'h0);
      check("R12 alert low", 32'(alert_n), 32'h0);
      ldac_pulse();
      check("R12 input zero", 32'(dac_out), 32'h0);
      send_frame(4'hB, 16'h0000, 1'b1, FB);
      check("R12 ctl zero", 32'(rb_data), 32'h0);

      // R11 ETS power-down
      send_frame(4'h4, 16'h0100, 1'b1, FB);
      send_frame(4'h3, 16'h2468, 1'b1, FB);
      over_temp = 1'b1;
      @(negedge clk);
      check("R11 pd set", 32'(pd_o), 32'h1);
      over_temp = 1'b0;
      send_frame(4'h3, 16'h7777, 1'b0, FB);
      check("R11 frame ignored", 32'(dac_out), 32'h2468);
      clear_pulse();
      check("R11 clear ignored", 32'(dac_out), 32'h2468);
      check("R11 pd latched", 32'(pd_o), 32'h1);
      hw_reset();
      check("R11 pd released by reset", 32'(pd_o), 32'h0);
      check("R1 dac after hw reset", 32'(dac_out), 32'h0);
      check("R1 alert after hw reset", 32'(alert_n), 32'h0);

      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end
endmodule